// File: doc/BRIEF.md
# Programmable Acquisition Scan Sequencer

This block drives the control side of a multichannel acquisition front end from a scan list held in on-chip storage. A scan begins on a start event. The start event comes from one of two sources, picked by a configuration bit. The first source is an internal interval timer that counts in 5 µs ticks. The second is an external scan clock, which is synchronised and edge-detected. During a scan the block walks the list from entry 0 up to a programmable last entry. For each entry it drives the channel number, gain code and polarity bit, waits a slot of one or two ticks, and then pulses a one-cycle convert strobe. A marker on the strobe flags the final entry of the scan.

A single write port loads both the list entries and the configuration registers. The tick is derived from the system clock by a prescaler. At a 200 MHz clock the default divider gives the 5 µs tick, and the 32-bit interval register then covers about six hours. A start event that arrives while a scan is still running is dropped. In that case a sticky overrun flag is raised.

Top module: `scan_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, convert, end_of_scan, busy and overrun are all 0.
- R2: In internal mode (control bit0 = enable = 1, bit1 = external = 0) a scan starts every N ticks, where N is the interval register at address 1 (0 is treated as 1). The first converts of consecutive scans are therefore N·TICK_DIV cycles apart.
- R3: In external mode (control bit1 = 1, enable = 1) every rising edge of ext_scan_clk that finds the block idle starts exactly one scan. This holds for high and low phases as short as two clock cycles.
- R4: A scan presents list entries 0, 1, … last in order, repeats allowed. Each entry is written at address 512+i with data bits [7:0] = channel, [10:8] = gain, [11] = bipolar. Each convert carries the fields of its entry.
- R5: Within a scan, consecutive converts are 1 tick apart when control bit2 = 0 and 2 ticks apart when bit2 = 1.
- R6: convert is high for exactly one cycle per entry.
- R7: ch_sel, gain_sel and bipolar hold their values through the cycle before a convert and through the convert cycle.
- R8: A start event during a running scan does not start a further scan. It sets overrun, which stays set until the control register (address 0) is written.
- R9: The length register at address 2 sets the scan length. 1 to 512 entries are taken as written, and 0 means one entry. end_of_scan comes with the convert of the last entry, and busy is 0 in the next cycle.
- R10: With enable = 0, neither the interval timer nor an external edge starts a scan.
- R11: busy is 1 from the scan start until the cycle after the last convert, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for list and configuration |
| wr_addr | input | 10 | Bit 9 set: list entry index in [8:0]; clear: 0 control, 1 interval, 2 length |
| wr_data | input | 32 | Write data |
| ext_scan_clk | input | 1 | Asynchronous external scan clock |
| ch_sel | output | 8 | Channel number of the current entry |
| gain_sel | output | 3 | Gain code of the current entry |
| bipolar | output | 1 | Polarity bit of the current entry |
| convert | output | 1 | One-cycle converter start strobe |
| end_of_scan | output | 1 | High with the convert of the last entry |
| busy | output | 1 | A scan is in progress |
| overrun | output | 1 | Sticky flag for a start event dropped during a scan |

## Verification
A wrong entry index or a corrupted list read shows at the very next convert, as a field mismatch against the scoreboard's queue. A fault in the slot counter or the interval counter shifts the spacing of convert strobes by a whole tick, which can be seen within one slot or one interval. A walker that runs past the last entry, or that accepts a start while busy, produces a convert that no queued item accounts for. That shows up within one slot of the fault. A lost overrun flag shows as soon as the scan that was overrun has finished.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int CH_W   = 8;
  localparam int GAIN_W = 3;

  typedef struct packed {
    logic              bipolar;
    logic [GAIN_W-1:0] gain;
    logic [CH_W-1:0]   ch;
  } scan_entry_t;

  localparam int ENTRY_W = $bits(scan_entry_t);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } walk_state_t;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/scan_trigger.sv
module scan_trigger #(
  parameter int INTV_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              ext_sel,
  input  logic [INTV_W-1:0] interval,
  input  logic              ext_in,
  output logic              start
);
  // synchroniser stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic [INTV_W-1:0]    ivl_cnt_q, ivl_cnt_d, ivl_last;
  logic                 int_run, ivl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  assign int_run  = enable & ~ext_sel;
  assign ivl_last = (interval == '0) ? '0 : interval - 1'b1;
  assign ivl_hit  = int_run & tick & (ivl_cnt_q == ivl_last);

  always_comb begin
    ivl_cnt_d = ivl_cnt_q;
    if (!int_run)     ivl_cnt_d = '0;
    else if (ivl_hit) ivl_cnt_d = '0;
    else if (tick)    ivl_cnt_d = ivl_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl_cnt_q <= '0;
    else        ivl_cnt_q <= ivl_cnt_d;
  end

  assign start = ext_sel ? (enable & ext_rise) : ivl_hit;
endmodule

// File: rtl/scan_list_ram.sv
module scan_list_ram
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  scan_entry_t      wdata,
  input  logic [IDX_W-1:0] raddr,
  output scan_entry_t      rdata
);
  scan_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scan_walker.sv
module scan_walker
  import scan_seq_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             slot_long,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             ovr_clr,
  output logic [IDX_W-1:0] rd_addr,
  input  scan_entry_t      rd_data,
  output scan_entry_t      cur,
  output logic             convert,
  output logic             eos,
  output logic             busy,
  output logic             overrun
);
  walk_state_t      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             slot_q, slot_d;
  scan_entry_t      cur_q, cur_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    slot_d  = slot_q;
    cur_d   = cur_q;
    rd_addr = idx_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        rd_addr = '0;
        if (start) begin
          st_d   = ST_SETTLE;
          idx_d  = '0;
          slot_d = 1'b0;
          cur_d  = rd_data;
        end
      end
      ST_SETTLE: begin
        if (tick) begin
          if (slot_q == slot_long) st_d = ST_CONV;
          else                     slot_d = 1'b1;
        end
      end
      ST_CONV: begin
        if (idx_q == last_idx) begin
          st_d = ST_IDLE;
        end else begin
          st_d   = ST_SETTLE;
          idx_d  = idx_q + 1'b1;
          slot_d = 1'b0;
          cur_d  = rd_data;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    ovr_d = ovr_q;
    if (ovr_clr)                   ovr_d = 1'b0;
    if (start && st_q != ST_IDLE)  ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      slot_q <= 1'b0;
      cur_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      slot_q <= slot_d;
      cur_q  <= cur_d;
      ovr_q  <= ovr_d;
    end
  end

  assign cur     = cur_q;
  assign convert = (st_q == ST_CONV);
  assign eos     = convert && (idx_q == last_idx);
  assign busy    = (st_q != ST_IDLE);
  assign overrun = ovr_q;
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int LIST_DEPTH  = 512,
  parameter int INTV_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(LIST_DEPTH):0] wr_addr,
  input  logic [INTV_W-1:0]        wr_data,
  input  logic                     ext_scan_clk,
  output logic [CH_W-1:0]          ch_sel,
  output logic [GAIN_W-1:0]        gain_sel,
  output logic                     bipolar,
  output logic                     convert,
  output logic                     end_of_scan,
  output logic                     busy,
  output logic                     overrun
);
  localparam int IDX_W = $clog2(LIST_DEPTH);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(LIST_DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration registers
  logic              en_q, ext_q, long_q;
  logic              en_d, ext_d, long_d;
  logic [INTV_W-1:0] ivl_q, ivl_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic              sel_list, sel_ctrl, sel_ivl, sel_len;
  logic [LEN_W-1:0]  len_in;

  assign sel_list = wr_en &  wr_addr[IDX_W];
  assign sel_ctrl = wr_en & ~wr_addr[IDX_W] & (wr_addr[IDX_W-1:0] == IDX_W'(0));
  assign sel_ivl  = wr_en & ~wr_addr[IDX_W] & (wr_addr[IDX_W-1:0] == IDX_W'(1));
  assign sel_len  = wr_en & ~wr_addr[IDX_W] & (wr_addr[IDX_W-1:0] == IDX_W'(2));
  assign len_in   = wr_data[LEN_W-1:0];

  always_comb begin
    en_d   = en_q;
    ext_d  = ext_q;
    long_d = long_q;
    ivl_d  = ivl_q;
    last_d = last_q;
    if (sel_ctrl) begin
      en_d   = wr_data[0];
      ext_d  = wr_data[1];
      long_d = wr_data[2];
    end
    if (sel_ivl) ivl_d = wr_data;
    if (sel_len) begin
      if (len_in == '0)          last_d = '0;
      else if (len_in > DEPTH_L) last_d = IDX_W'(LIST_DEPTH - 1);
      else                       last_d = IDX_W'(len_in - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= 1'b0;
      ext_q  <= 1'b0;
      long_q <= 1'b0;
      ivl_q  <= INTV_W'(1);
      last_q <= '0;
    end else begin
      en_q   <= en_d;
      ext_q  <= ext_d;
      long_q <= long_d;
      ivl_q  <= ivl_d;
      last_q <= last_d;
    end
  end

  logic             tick, start;
  logic [IDX_W-1:0] rd_addr;
  scan_entry_t      rd_data, cur, wentry;

  assign wentry = scan_entry_t'(wr_data[ENTRY_W-1:0]);

  scan_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  scan_trigger #(.INTV_W(INTV_W), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .enable(en_q), .ext_sel(ext_q),
    .interval(ivl_q), .ext_in(ext_scan_clk), .start(start)
  );

  scan_list_ram #(.DEPTH(LIST_DEPTH), .IDX_W(IDX_W)) u_list (
    .clk(clk), .we(sel_list), .waddr(wr_addr[IDX_W-1:0]), .wdata(wentry),
    .raddr(rd_addr), .rdata(rd_data)
  );

  scan_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .start(start), .slot_long(long_q),
    .last_idx(last_q), .ovr_clr(sel_ctrl), .rd_addr(rd_addr), .rd_data(rd_data),
    .cur(cur), .convert(convert), .eos(end_of_scan), .busy(busy), .overrun(overrun)
  );

  assign ch_sel   = cur.ch;
  assign gain_sel = cur.gain;
  assign bipolar  = cur.bipolar;
endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    ch_sel,
  input logic [2:0]    gain_sel,
  input logic          bipolar,
  input logic          convert,
  input logic          end_of_scan,
  input logic          busy,
  input logic          overrun
);
  AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    convert |=> !convert);                                               // R6
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    convert |-> ($stable(ch_sel) && $stable(gain_sel) && $stable(bipolar))); // R7
  AST_EOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_scan |=> !busy);                                              // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(wr_en && wr_addr == '0)) |=> overrun);                 // R8
  AST_CONV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    convert |-> busy);                                                   // R11
endmodule

bind scan_sequencer scan_seq_checker #(.AW($clog2(LIST_DEPTH) + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ch_sel(ch_sel),
  .gain_sel(gain_sel), .bipolar(bipolar), .convert(convert),
  .end_of_scan(end_of_scan), .busy(busy), .overrun(overrun)
);

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_scan_clk = 1'b0;
  logic [7:0]  ch_sel;
  logic [2:0]  gain_sel;
  logic        bipolar, convert, end_of_scan, busy, overrun;

  always #2.5 clk = ~clk;

  scan_sequencer #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_scan_clk(ext_scan_clk), .ch_sel(ch_sel), .gain_sel(gain_sel),
    .bipolar(bipolar), .convert(convert), .end_of_scan(end_of_scan),
    .busy(busy), .overrun(overrun)
  );

  int          checks = 0, fails = 0, cyc = 0;
  logic [12:0] expq[$];
  int          ctimes[$];
  logic [11:0] img [512];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && convert) begin
      logic [12:0] got, e;
      got = {end_of_scan, bipolar, gain_sel, ch_sel};
      ctimes.push_back(cyc);
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R10", $sformatf("unexpected convert actual %h expected none", got));
      end else begin
        e = expq.pop_front();
        chk(got == e, "R4", $sformatf("entry actual %h expected %h", got, e));
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_scan(input int n);
    for (int i = 0; i < n; i++) expq.push_back({(i == n - 1), img[i]});
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_scan_clk = 1'b1;
    repeat (2) @(negedge clk);
    ext_scan_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    wait (expq.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int n;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk({convert, end_of_scan, busy, overrun} == 4'b0, "R1",
        $sformatf("in reset actual %b expected 0000", {convert, end_of_scan, busy, overrun}));
    rst_n = 1'b1;
    @(negedge clk);
    chk({convert, end_of_scan, busy, overrun} == 4'b0, "R1",
        $sformatf("after release actual %b expected 0000", {convert, end_of_scan, busy, overrun}));
    repeat (3) @(negedge clk);

    // list with repeated, non-ascending channels
    img[0] = {1'b0, 3'd1, 8'd7};
    img[1] = {1'b1, 3'd5, 8'd3};
    img[2] = {1'b1, 3'd0, 8'd7};
    img[3] = {1'b0, 3'd7, 8'd0};
    img[4] = {1'b1, 3'd2, 8'd255};
    for (int i = 0; i < 5; i++) wr(512 + i, int'(img[i]));
    wr(2, 5);
    wr(1, 30);

    // R2 internal timer, R4 order, R5 short slot
    ctimes.delete();
    push_scan(5); push_scan(5);
    wr(0, 1);
    wait_idle();
    wr(0, 0);
    chk(ctimes.size() == 10, "R4", $sformatf("converts actual %0d expected 10", ctimes.size()));
    if (ctimes.size() >= 6) begin
      chk(ctimes[1] - ctimes[0] == DIV, "R5",
          $sformatf("short gap actual %0d expected %0d", ctimes[1] - ctimes[0], DIV));
      chk(ctimes[5] - ctimes[0] == 30 * DIV, "R2",
          $sformatf("scan period actual %0d expected %0d", ctimes[5] - ctimes[0], 30 * DIV));
    end

    // R10 disabled: neither source starts
    n = ctimes.size();
    wr(0, 2);
    ext_pulse();
    repeat (200) @(negedge clk);
    chk(ctimes.size() == n, "R10", $sformatf("converts actual %0d expected %0d", ctimes.size() - n, 0));
    chk(busy == 1'b0, "R10", $sformatf("busy actual %b expected 0", busy));

    // R5 long slot, R11 busy
    wr(0, 7);
    ctimes.delete();
    push_scan(5);
    ext_pulse();
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R11", $sformatf("busy mid-scan actual %b expected 1", busy));
    wait_idle();
    chk(busy == 1'b0, "R11", $sformatf("busy after scan actual %b expected 0", busy));
    if (ctimes.size() >= 5)
      chk(ctimes[4] - ctimes[3] == 2 * DIV, "R5",
          $sformatf("long gap actual %0d expected %0d", ctimes[4] - ctimes[3], 2 * DIV));

    // R8 overrun
    wr(0, 7);
    ctimes.delete();
    push_scan(5);
    ext_pulse();
    repeat (10) @(negedge clk);
    ext_pulse();
    wait_idle();
    repeat (40) @(negedge clk);
    chk(ctimes.size() == 5, "R8", $sformatf("converts actual %0d expected 5", ctimes.size()));
    chk(overrun == 1'b1, "R8", $sformatf("overrun actual %b expected 1", overrun));
    wr(0, 7);
    @(negedge clk);
    chk(overrun == 1'b0, "R8", $sformatf("overrun after clear actual %b expected 0", overrun));

    // R3 short external pulses, one-entry scans
    wr(2, 1);
    wr(0, 3);
    ctimes.delete();
    for (int k = 0; k < 3; k++) begin
      push_scan(1);
      ext_pulse();
      repeat (16) @(negedge clk);
    end
    wait_idle();
    chk(ctimes.size() == 3, "R3", $sformatf("scans actual %0d expected 3", ctimes.size()));
    chk(overrun == 1'b0, "R3", $sformatf("overrun actual %b expected 0", overrun));

    // R9 length 0 means one entry
    wr(2, 0);
    ctimes.delete();
    push_scan(1);
    ext_pulse();
    wait_idle();
    repeat (20) @(negedge clk);
    chk(ctimes.size() == 1, "R9", $sformatf("len0 converts actual %0d expected 1", ctimes.size()));

    // R9 full 512-entry list
    for (int i = 0; i < 512; i++) begin
      img[i] = {1'(i >> 3), 3'(i), 8'(i * 37)};
      wr(512 + i, int'(img[i]));
    end
    wr(2, 512);
    ctimes.delete();
    push_scan(512);
    ext_pulse();
    wait_idle();
    repeat (20) @(negedge clk);
    chk(ctimes.size() == 512, "R9", $sformatf("full converts actual %0d expected 512", ctimes.size()));
    chk(busy == 1'b0, "R9", $sformatf("busy after full scan actual %b expected 0", busy));

    finish_run();
  end
endmodule